// File: doc/BRIEF.md
# Shaped Pseudo-Random Excitation and Correlator for Loop Identification

This block perturbs the duty command of a digitally controlled switching converter and measures how the converter answers, one switching cycle at a time. A 10-bit maximal-length shift register gives a ±1 sequence. A fixed second-order high-pass shaping filter turns it into a multi-level duty offset. That offset is added to the compensator's nominal duty word and clamped to a programmable duty window. A sticky flag records whether the clamp ever engaged during a run.

The sensed output-voltage error goes through the exact reciprocal of the shaping filter. This undoes the shaping, so high-frequency content stays above ADC quantization while the identified response is still that of the plant. A bank of accumulators then builds the cross-correlation between the raw ±1 sequence and the filtered error over a range of lags. The result approximates the plant impulse response and is read back through a simple address/data port.

A start pulse clears all state and runs exactly one full sequence period of 1023 strobes, after which the block raises a done flag. The frequency transform of the result is done elsewhere.

Top module: `prbs_ident_core`

## Requirements
- R1: The sequence register is loaded with all ones (0x3FF) by start. On each run step it shifts left and takes bit9 XOR bit6 into bit 0. Bit 9 sets the excitation sign (1 gives +amp, 0 gives −amp). A run ends after exactly 1023 strobes.
- R2: The injection is inj(n) = (28672·u(n) − 38732·u(n−1) + 11096·u(n−2) + 1703·inj(n−1) − 177·inj(n−2)) arithmetically shifted right by 12. The coefficients are Q12, u = ±amp, and all states are zero at start.
- R3: On a strobe, dutyOut is registered as nominal + inj clamped to [dMin, dMax]. Without a strobe, or in a cycle with start, dutyOut holds its value.
- R4: satFlag is set when the clamp engages on a run step. It stays set until the next start, which clears it. It does not change while idle.
- R5: The filtered error is w(n) = (q·585) arithmetically shifted right by 24, where q = ((4096·e(n) − 1703·e(n−1) + 177·e(n−2)) shifted left by 12) + 38732·w(n−1) − 11096·w(n−2). Here e is the signed error input and w is Q12.
- R6: On each run step n, the accumulator for lag m adds w(n) if the excitation sign of step n−m was positive and subtracts it if negative. Steps before the run are skipped. rdData shows the accumulator selected by rdAddr in the same cycle.
- R7: start clears the accumulators, the filter states and the flags, and raises busy on the next cycle, even in the middle of a run. A strobe in the same cycle as start is not processed. busy and done are never high together.
- R8: While idle, a strobe loads dutyOut with nominal clamped to [dMin, dMax], without injection and without touching satFlag.
- R9: After reset, dutyOut, busy, done, satFlag and every accumulator are zero.
- R10: done stays high, and the accumulators keep their values, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that clears state and begins a run |
| strobe | input | 1 | One pulse per switching cycle |
| amp | input | AMP_W | Excitation amplitude in duty LSBs |
| nominal | input | DW | Compensator duty word |
| dMin | input | DW | Lower duty limit |
| dMax | input | DW | Upper duty limit |
| errIn | input | ERR_W | Signed sensed output-voltage error |
| rdAddr | input | LAG_AW | Lag index to read |
| dutyOut | output | DW | Perturbed and clamped duty |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| satFlag | output | 1 | Clamp engaged during the run |
| rdData | output | ACC_W | Signed correlation value at rdAddr |

## Verification
The bound checker watches the cycle-level rules on every clock. These cover the duty staying inside the window after a strobe, the duty holding between strobes, satFlag being sticky and frozen while idle, start clearing the flags, busy and done never overlapping, and the idle pass-through of an in-range nominal word. The arithmetic cannot be shown by properties. This covers the shaping recursion, the reciprocal filter's output, the lag sums and the exact count of 1023 strobes. Only the bench scenarios show these, by comparing against an integer model at every cycle and reading back every lag after runs with sparse strobes, heavy saturation and a restart in the middle of a run.

// File: rtl/prbs_ident_pkg.sv
package prbs_ident_pkg;
  // sequence register
  localparam int LFSR_W  = 10;
  localparam int TAP_LO  = 6;
  localparam int FRAC    = 12;
  // shaping filter, Q12: numerator b0..b2, denominator 1 + a1 z^-1 + a2 z^-2
  localparam int COEF_B0 = 28672;
  localparam int COEF_B1 = -38732;
  localparam int COEF_B2 = 11096;
  localparam int COEF_A1 = -1703;
  localparam int COEF_A2 = 177;
  // reciprocal of b0 in the reciprocal filter: 2^INV_SH / COEF_B0
  localparam int INV_B0  = 585;
  localparam int INV_SH  = 24;

  typedef struct packed {
    logic clear;
    logic step;
  } identCtl_t;
endpackage

// File: rtl/ident_ctrl.sv
module ident_ctrl
  import prbs_ident_pkg::*;
#(
  parameter int SEQ_LEN = (1 << LFSR_W) - 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      strobe,
  output identCtl_t ctl,
  output logic      busy,
  output logic      done
);
  localparam int CNT_W = $clog2(SEQ_LEN + 1);

  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    ctl.clear = start;
    ctl.step  = strobe && busy && !start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      stepCnt <= '0;
    end else if (ctl.step) begin
      if (stepCnt == CNT_W'(SEQ_LEN - 1)) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        stepCnt <= '0;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ident_datapath.sv
module ident_datapath
  import prbs_ident_pkg::*;
#(
  parameter int DW       = 10,
  parameter int AMP_W    = 8,
  parameter int ERR_W    = 12,
  parameter int INJ_W    = 16,
  parameter int W_W      = 32,
  parameter int NUM_LAGS = 32,
  parameter int ACC_W    = W_W + LFSR_W,
  parameter int LAG_AW   = $clog2(NUM_LAGS),
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  identCtl_t                ctl,
  input  logic                     strobe,
  input  logic [AMP_W-1:0]         amp,
  input  logic [DW-1:0]            nominal,
  input  logic [DW-1:0]            dMin,
  input  logic [DW-1:0]            dMax,
  input  logic signed [ERR_W-1:0]  errIn,
  input  logic [LAG_AW-1:0]        rdAddr,
  output logic [DW-1:0]            dutyOut,
  output logic                     satFlag,
  output logic signed [ACC_W-1:0]  rdData
);
  localparam int MW = 64;
  localparam int RW = INJ_W + 2;
  localparam logic signed [MW-1:0] cB0  = MW'(COEF_B0);
  localparam logic signed [MW-1:0] cB1  = MW'(COEF_B1);
  localparam logic signed [MW-1:0] cB2  = MW'(COEF_B2);
  localparam logic signed [MW-1:0] cA1  = MW'(COEF_A1);
  localparam logic signed [MW-1:0] cA2  = MW'(COEF_A2);
  localparam logic signed [MW-1:0] cInv = MW'(INV_B0);

  // sequence register
  logic [LFSR_W-1:0] lfsr;
  logic              curBit;
  assign curBit = lfsr[LFSR_W-1];

  // shaping filter
  logic signed [INJ_W-1:0] ampS, uNow, u1, u2, inj1, inj2, injNow, injEff;
  logic signed [MW-1:0]    preAcc;
  assign ampS = signed'(INJ_W'(amp));
  assign uNow = curBit ? ampS : -ampS;
  always_comb begin
    preAcc = cB0 * MW'(uNow) + cB1 * MW'(u1) + cB2 * MW'(u2)
           - cA1 * MW'(inj1) - cA2 * MW'(inj2);
    injNow = INJ_W'(preAcc >>> FRAC);
    injEff = ctl.step ? injNow : '0;
  end

  // duty window
  logic signed [RW-1:0] rawDuty, loS, hiS;
  logic                 clampHi, clampLo;
  logic [DW-1:0]        dutyNext;
  always_comb begin
    rawDuty  = signed'(RW'(nominal)) + RW'(injEff);
    loS      = signed'(RW'(dMin));
    hiS      = signed'(RW'(dMax));
    clampHi  = rawDuty > hiS;
    clampLo  = rawDuty < loS;
    dutyNext = clampHi ? dMax : (clampLo ? dMin : rawDuty[DW-1:0]);
  end

  // reciprocal filter
  logic signed [ERR_W-1:0] e1, e2;
  logic signed [W_W-1:0]   w1, w2, wNow;
  logic signed [MW-1:0]    postAcc, postScaled;
  always_comb begin
    postAcc = (((MW'(errIn) <<< FRAC) + cA1 * MW'(e1) + cA2 * MW'(e2)) <<< FRAC)
            - cB1 * MW'(w1) - cB2 * MW'(w2);
    postScaled = postAcc * cInv;
    wNow       = W_W'(postScaled >>> INV_SH);
  end

  // lag history: sign and valid of earlier steps
  logic [NUM_LAGS-2:0]    uHist, vHist;
  logic [NUM_LAGS-1:0]    lagSign, lagValid;
  logic signed [ACC_W-1:0] wExt;
  logic signed [ACC_W-1:0] corrAcc [NUM_LAGS];
  assign lagSign  = {uHist, curBit};
  assign lagValid = {vHist, 1'b1};
  assign wExt     = ACC_W'(wNow);
  assign rdData   = corrAcc[rdAddr];

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      lfsr    <= SEED;
      u1      <= '0;
      u2      <= '0;
      inj1    <= '0;
      inj2    <= '0;
      e1      <= '0;
      e2      <= '0;
      w1      <= '0;
      w2      <= '0;
      uHist   <= '0;
      vHist   <= '0;
      satFlag <= 1'b0;
    end else if (ctl.step) begin
      lfsr    <= {lfsr[LFSR_W-2:0], lfsr[LFSR_W-1] ^ lfsr[TAP_LO]};
      u2      <= u1;
      u1      <= uNow;
      inj2    <= inj1;
      inj1    <= injNow;
      e2      <= e1;
      e1      <= errIn;
      w2      <= w1;
      w1      <= wNow;
      uHist   <= lagSign[NUM_LAGS-2:0];
      vHist   <= lagValid[NUM_LAGS-2:0];
      satFlag <= satFlag | clampHi | clampLo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      for (int m = 0; m < NUM_LAGS; m++) corrAcc[m] <= '0;
    end else if (ctl.step) begin
      for (int m = 0; m < NUM_LAGS; m++) begin
        if (lagValid[m]) corrAcc[m] <= lagSign[m] ? corrAcc[m] + wExt : corrAcc[m] - wExt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dutyOut <= '0;
    else if (strobe && !ctl.clear) dutyOut <= dutyNext;
  end
endmodule

// File: rtl/prbs_ident_core.sv
module prbs_ident_core
  import prbs_ident_pkg::*;
#(
  parameter int DW       = 10,
  parameter int AMP_W    = 8,
  parameter int ERR_W    = 12,
  parameter int INJ_W    = 16,
  parameter int W_W      = 32,
  parameter int NUM_LAGS = 32,
  parameter int ACC_W    = W_W + LFSR_W,
  parameter int LAG_AW   = $clog2(NUM_LAGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    strobe,
  input  logic [AMP_W-1:0]        amp,
  input  logic [DW-1:0]           nominal,
  input  logic [DW-1:0]           dMin,
  input  logic [DW-1:0]           dMax,
  input  logic signed [ERR_W-1:0] errIn,
  input  logic [LAG_AW-1:0]       rdAddr,
  output logic [DW-1:0]           dutyOut,
  output logic                    busy,
  output logic                    done,
  output logic                    satFlag,
  output logic signed [ACC_W-1:0] rdData
);
  identCtl_t ctl;

  ident_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .strobe(strobe),
    .ctl(ctl), .busy(busy), .done(done)
  );

  ident_datapath #(
    .DW(DW), .AMP_W(AMP_W), .ERR_W(ERR_W), .INJ_W(INJ_W), .W_W(W_W),
    .NUM_LAGS(NUM_LAGS), .ACC_W(ACC_W), .LAG_AW(LAG_AW)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .strobe(strobe), .amp(amp),
    .nominal(nominal), .dMin(dMin), .dMax(dMax), .errIn(errIn),
    .rdAddr(rdAddr), .dutyOut(dutyOut), .satFlag(satFlag), .rdData(rdData)
  );
endmodule

// File: rtl/ident_chk.sv
module ident_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          strobe,
  input logic [DW-1:0] nominal,
  input logic [DW-1:0] dMin,
  input logic [DW-1:0] dMax,
  input logic [DW-1:0] dutyOut,
  input logic          busy,
  input logic          done,
  input logic          satFlag
);
  // R3
  duty_range_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe) && !$past(start) && ($past(dMin) <= $past(dMax)))
      |-> (dutyOut >= $past(dMin) && dutyOut <= $past(dMax)));

  // R3
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(strobe) || $past(start)) |-> $stable(dutyOut));

  // R4
  sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(satFlag) && !$past(start)) |-> satFlag);

  // R4
  sat_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(busy) && !$past(start)) |-> (satFlag == $past(satFlag)));

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(start) |-> (busy && !done && !satFlag));

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R1
  done_from_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(done) && !$past(start)) |-> done);

  // R8
  idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe) && !$past(start) && !$past(busy) &&
     $past(nominal) >= $past(dMin) && $past(nominal) <= $past(dMax))
      |-> (dutyOut == $past(nominal)));
endmodule

bind prbs_ident_core ident_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .strobe(strobe), .nominal(nominal),
  .dMin(dMin), .dMax(dMax), .dutyOut(dutyOut), .busy(busy), .done(done),
  .satFlag(satFlag)
);

// File: tb/prbs_ident_core_tb.sv
module prbs_ident_core_tb;
  localparam int CLK_P  = 10;
  localparam int DW     = 10;
  localparam int AMP_W  = 8;
  localparam int ERR_W  = 12;
  localparam int NL     = 32;
  localparam int ACC_W  = 42;
  localparam int LAG_AW = 5;

  logic clk = 1'b0;
  logic rst, start, strobe;
  logic [AMP_W-1:0] amp;
  logic [DW-1:0] nominal, dMin, dMax, dutyOut;
  logic signed [ERR_W-1:0] errIn;
  logic [LAG_AW-1:0] rdAddr;
  logic busy, done, satFlag;
  logic signed [ACC_W-1:0] rdData;

  prbs_ident_core u_dut (
    .clk(clk), .rst(rst), .start(start), .strobe(strobe), .amp(amp),
    .nominal(nominal), .dMin(dMin), .dMax(dMax), .errIn(errIn),
    .rdAddr(rdAddr), .dutyOut(dutyOut), .busy(busy), .done(done),
    .satFlag(satFlag), .rdData(rdData)
  );

  always #(CLK_P/2) clk = ~clk;

  int errs = 0;
  int checks = 0;

  // behavioural reference state
  int mDuty = 0, mBusy = 0, mDone = 0, mSat = 0, mCnt = 0;
  int lfsr = 1023;
  int u1, u2, i1, i2, e1, e2, w1, w2;
  longint mAcc [NL];
  int hist [$];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic modelStep(input bit st, input bit sb, input int nom, input int lo,
                           input int hi, input int a, input int e);
    longint p, q;
    int u, inj, raw, w, sgn, s;
    if (st) begin
      mBusy = 1; mDone = 0; mSat = 0; mCnt = 0; lfsr = 1023;
      u1 = 0; u2 = 0; i1 = 0; i2 = 0; e1 = 0; e2 = 0; w1 = 0; w2 = 0;
      for (int m = 0; m < NL; m++) mAcc[m] = 0;
      hist.delete();
    end else if (sb) begin
      if (mBusy == 1) begin
        sgn = (lfsr >> 9) & 1;
        u = sgn ? a : -a;
        p = 28672 * longint'(u) - 38732 * longint'(u1) + 11096 * longint'(u2)
          + 1703 * longint'(i1) - 177 * longint'(i2);
        inj = int'(p >>> 12);
        raw = nom + inj;
        if (raw > hi) begin mDuty = hi; mSat = 1; end
        else if (raw < lo) begin mDuty = lo; mSat = 1; end
        else mDuty = raw;
        q = ((4096 * longint'(e) - 1703 * longint'(e1) + 177 * longint'(e2)) <<< 12)
          + 38732 * longint'(w1) - 11096 * longint'(w2);
        w = int'((q * 585) >>> 24);
        for (int m = 0; m < NL; m++) begin
          if (m == 0) s = sgn ? 1 : -1;
          else if (m - 1 < hist.size()) s = hist[m-1];
          else s = 0;
          mAcc[m] += longint'(s) * longint'(w);
        end
        hist.push_front(sgn ? 1 : -1);
        if (hist.size() > NL - 1) void'(hist.pop_back());
        u2 = u1; u1 = u; i2 = i1; i1 = inj; e2 = e1; e1 = e; w2 = w1; w1 = w;
        lfsr = ((lfsr << 1) | (((lfsr >> 9) ^ (lfsr >> 6)) & 1)) & 1023;
        mCnt++;
        if (mCnt == 1023) begin mBusy = 0; mDone = 1; mCnt = 0; end
      end else begin
        if (nom > hi) mDuty = hi;
        else if (nom < lo) mDuty = lo;
        else mDuty = nom;
      end
    end
  endtask

  task automatic cyc(input bit st, input bit sb);
    int e;
    @(negedge clk);
    start = st;
    strobe = sb;
    e = mDuty - int'(nominal);
    errIn = ERR_W'(e);
    @(posedge clk);
    #1;
    modelStep(st, sb, int'(nominal), int'(dMin), int'(dMax), int'(amp), e);
    chk(mBusy ? "R2 R3 duty" : "R8 duty", longint'(dutyOut), longint'(mDuty));
    chk("R7 busy", longint'(busy), longint'(mBusy));
    chk("R7 done", longint'(done), longint'(mDone));
    chk("R4 sat", longint'(satFlag), longint'(mSat));
  endtask

  task automatic readLags(input string tag);
    for (int m = 0; m < NL; m++) begin
      @(negedge clk);
      start = 1'b0;
      strobe = 1'b0;
      rdAddr = LAG_AW'(m);
      #1;
      chk(tag, longint'(rdData), mAcc[m]);
    end
  endtask

  task automatic runToDone(input int gap, output int n);
    n = 0;
    while (done !== 1'b1 && n < 1100) begin
      cyc(1'b0, 1'b1);
      n++;
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0);
    end
  endtask

  initial begin
    int n;
    rst = 1'b1; start = 1'b0; strobe = 1'b0; amp = '0; nominal = '0;
    dMin = '0; dMax = '1; errIn = '0; rdAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk("R9 duty", longint'(dutyOut), 0);
    chk("R9 busy", longint'(busy), 0);
    chk("R9 done", longint'(done), 0);
    chk("R9 sat", longint'(satFlag), 0);
    chk("R9 acc", longint'(rdData), 0);

    // R8 idle pass-through and clamp, no saturation flag
    dMin = 10'd100; dMax = 10'd900; nominal = 10'd500;
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    nominal = 10'd950;
    cyc(1'b0, 1'b1);
    nominal = 10'd20;
    cyc(1'b0, 1'b1);
    chk("R8 sat idle", longint'(satFlag), 0);

    // run 1: sparse strobes, small amplitude
    amp = 8'd20; nominal = 10'd512;
    cyc(1'b1, 1'b0);
    runToDone(1, n);
    chk("R1 run length", longint'(n), 1023);
    readLags("R6 lag");
    // R10 done and results persist across idle strobes
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    chk("R10 done held", longint'(done), 1);
    readLags("R10 lag");

    // run 2: heavy saturation, then restart mid-run with strobe in same cycle
    amp = 8'd200; nominal = 10'd800; dMin = 10'd50; dMax = 10'd950;
    cyc(1'b1, 1'b0);
    for (int k = 0; k < 300; k++) cyc(1'b0, 1'b1);
    chk("R4 sat set", longint'(satFlag), 1);
    amp = 8'd30; nominal = 10'd500;
    cyc(1'b1, 1'b1);
    chk("R7 restart busy", longint'(busy), 1);
    chk("R4 sat cleared", longint'(satFlag), 0);
    runToDone(0, n);
    chk("R1 run length after restart", longint'(n), 1023);
    chk("R4 sat clear at end", longint'(satFlag), 0);
    readLags("R5 R6 lag");

    @(negedge clk);
    summary();
    $finish;
  end
endmodule